// File: doc/BRIEF.md
# Periodic Timer Call Injector

This block sits next to the instruction sequencer of a single-task processor and forces a subroutine call to a programmed address at a fixed clock interval. Software writes a period, in clocks, and a target address. A down-counter then expires once per period and raises a pending request. The request is held until the sequencer reports an instruction boundary that is not part of an immediate-extension pair and not directly after a prefix that rewrites the next instruction's operand fields.

When the request is accepted, the block captures the address of the next instruction that has not executed and the processor flags. It then holds the sequencer for a fixed number of pad cycles, so the time from acceptance to call entry is the same whatever opcode was in flight. At the end of the pad it pulses the inject strobe for one cycle and presents the target and the saved context. Further calls are masked until the called routine signals its return. There is a single context, because the processor runs only one task.

Top module: `tcall_injector`

## Requirements
- R1: After a period P of 1 or more is written in cycle w, the timer expires in cycles w+P, w+2P and so on, reloading from P without drift. `inject_target` always shows the last target address written.
- R2: A period of 0 disables the timer, so no request is raised and `stall_req` stays low.
- R3: No request is accepted in a cycle where `aug_pending` is high.
- R4: No request is accepted in a cycle where `alt_pending` is high.
- R5: A request accepted in cycle k gives `stall_req` high in cycles k+1 to k+LAT_CYCLES, with `inject_call` high only in cycle k+LAT_CYCLES. The inject strobe is exactly one cycle wide.
- R6: `save_pc` and `save_flags` hold the `cur_pc` and `cur_flags` values from the acceptance cycle, and stay stable through the pad and the inject cycle.
- R7: After the inject cycle, `handler_active` stays high until a cycle with `ret_done`. No request is accepted while it is high, and an expiry in that time stays pending and is accepted after the return.
- R8: Writing either the period or the target clears a pending request, and no request is accepted in the write cycle.
- R9: After reset, `inject_call`, `stall_req` and `handler_active` are low, `save_pc`, `save_flags` and `inject_target` are zero, and the timer is disabled.
- R10: A request is accepted only in a cycle where `insn_boundary` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| period_we | input | 1 | Write strobe for the period |
| period_wdata | input | CNT_W | New period in clocks (0 disables) |
| target_we | input | 1 | Write strobe for the call target |
| target_wdata | input | ADDR_W | New call target address |
| insn_boundary | input | 1 | Sequencer is between instructions this cycle |
| aug_pending | input | 1 | Immediate-extension prefix awaiting its instruction |
| alt_pending | input | 1 | Field-rewrite prefix awaiting its instruction |
| cur_pc | input | ADDR_W | Address of the next instruction not yet executed |
| cur_flags | input | FLAG_W | Current processor flags |
| ret_done | input | 1 | Called routine has returned |
| stall_req | output | 1 | Hold the sequencer (entry pad in progress) |
| inject_call | output | 1 | One-cycle strobe: enter the call now |
| inject_target | output | ADDR_W | Call target address |
| save_pc | output | ADDR_W | Return address to save |
| save_flags | output | FLAG_W | Flags to save |
| handler_active | output | 1 | Called routine is running |

## Verification
The main function is driven four ways. A free-running boundary stream with immediate returns shows the period spacing and the fixed pad length. Long prefix holds, with each prefix kind tried separately, show that a pending request waits for a clean boundary and is not dropped. A withheld return shows that an expiry inside the routine is kept and accepted after the return. Long random runs mix boundary gaps, both prefix kinds, late returns and reconfiguration landing in any state, and tell apart off-by-one errors in the reload, in the pad count and in the order in which clearing, setting and acceptance of the pending flag take effect.

// File: rtl/tcall_pkg.sv
package tcall_pkg;

  // Entry sequence: waiting, padding toward the call, routine running.
  typedef enum logic [1:0] {
    ENT_IDLE    = 2'd0,
    ENT_PAD     = 2'd1,
    ENT_HANDLER = 2'd2
  } entry_state_e;

  // Bits needed to count down from n-1 to zero.
  function automatic int unsigned down_cnt_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/tcall_period_timer.sv
module tcall_period_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             period_we,
  input  logic [CNT_W-1:0] period_wdata,
  output logic             expire
);

  logic [CNT_W-1:0] period_q, period_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             running;
  logic             tick_en;

  assign running = (period_q != '0);
  assign tick_en = period_we | running;

  always_comb begin
    period_d = period_q;
    cnt_d    = cnt_q;
    expire   = 1'b0;
    if (period_we) begin
      period_d = period_wdata;
      cnt_d    = (period_wdata == '0) ? '0 : (period_wdata - CNT_W'(1));
    end else if (running) begin
      if (cnt_q == '0) begin
        expire = 1'b1;
        cnt_d  = period_q - CNT_W'(1);
      end else begin
        cnt_d  = cnt_q - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_q <= '0;
      cnt_q    <= '0;
    end else if (tick_en) begin
      period_q <= period_d;
      cnt_q    <= cnt_d;
    end
  end

endmodule

// File: rtl/tcall_request_gate.sv
module tcall_request_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic cfg_clear,
  input  logic insn_boundary,
  input  logic aug_pending,
  input  logic alt_pending,
  input  logic entry_idle,
  output logic take
);

  logic pending_q, pending_d;
  logic safe_point;

  // A boundary is safe only when no prefix is bound to the next instruction.
  assign safe_point = insn_boundary & ~aug_pending & ~alt_pending;
  assign take       = pending_q & safe_point & entry_idle & ~cfg_clear;

  always_comb begin
    pending_d = pending_q;
    if (cfg_clear) begin
      pending_d = 1'b0;
    end else if (expire) begin
      pending_d = 1'b1;
    end else if (take) begin
      pending_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_q <= 1'b0;
    end else begin
      pending_q <= pending_d;
    end
  end

endmodule

// File: rtl/tcall_entry_pad.sv
module tcall_entry_pad
  import tcall_pkg::*;
#(
  parameter int unsigned ADDR_W     = 20,
  parameter int unsigned FLAG_W     = 2,
  parameter int unsigned LAT_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [ADDR_W-1:0] cur_pc,
  input  logic [FLAG_W-1:0] cur_flags,
  input  logic              ret_done,
  output logic              entry_idle,
  output logic              stall_req,
  output logic              inject_call,
  output logic              handler_active,
  output logic [ADDR_W-1:0] save_pc,
  output logic [FLAG_W-1:0] save_flags
);

  localparam int unsigned PAD_W   = down_cnt_width(LAT_CYCLES);
  localparam logic [PAD_W-1:0] PAD_LOAD = PAD_W'(LAT_CYCLES - 1);

  entry_state_e      state_q, state_d;
  logic [PAD_W-1:0]  pad_q, pad_d;
  logic              pad_done;
  logic              ctx_en;
  logic [ADDR_W-1:0] spc_q;
  logic [FLAG_W-1:0] sflg_q;

  assign pad_done = (pad_q == '0);
  assign ctx_en   = take & (state_q == ENT_IDLE);

  always_comb begin
    state_d = state_q;
    pad_d   = pad_q;
    unique case (state_q)
      ENT_IDLE: begin
        if (take) begin
          state_d = ENT_PAD;
          pad_d   = PAD_LOAD;
        end
      end
      ENT_PAD: begin
        if (pad_done) begin
          state_d = ENT_HANDLER;
        end else begin
          pad_d = pad_q - PAD_W'(1);
        end
      end
      ENT_HANDLER: begin
        if (ret_done) begin
          state_d = ENT_IDLE;
        end
      end
      default: state_d = ENT_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ENT_IDLE;
      pad_q   <= '0;
    end else begin
      state_q <= state_d;
      pad_q   <= pad_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spc_q  <= '0;
      sflg_q <= '0;
    end else if (ctx_en) begin
      spc_q  <= cur_pc;
      sflg_q <= cur_flags;
    end
  end

  assign entry_idle     = (state_q == ENT_IDLE);
  assign stall_req      = (state_q == ENT_PAD);
  assign inject_call    = stall_req & pad_done;
  assign handler_active = (state_q == ENT_HANDLER);
  assign save_pc        = spc_q;
  assign save_flags     = sflg_q;

endmodule

// File: rtl/tcall_injector.sv
module tcall_injector #(
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned ADDR_W     = 20,
  parameter int unsigned FLAG_W     = 2,
  parameter int unsigned LAT_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              period_we,
  input  logic [CNT_W-1:0]  period_wdata,
  input  logic              target_we,
  input  logic [ADDR_W-1:0] target_wdata,
  input  logic              insn_boundary,
  input  logic              aug_pending,
  input  logic              alt_pending,
  input  logic [ADDR_W-1:0] cur_pc,
  input  logic [FLAG_W-1:0] cur_flags,
  input  logic              ret_done,
  output logic              stall_req,
  output logic              inject_call,
  output logic [ADDR_W-1:0] inject_target,
  output logic [ADDR_W-1:0] save_pc,
  output logic [FLAG_W-1:0] save_flags,
  output logic              handler_active
);

  logic              expire;
  logic              cfg_clear;
  logic              take;
  logic              entry_idle;
  logic [ADDR_W-1:0] target_q;

  assign cfg_clear = period_we | target_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      target_q <= '0;
    end else if (target_we) begin
      target_q <= target_wdata;
    end
  end

  assign inject_target = target_q;

  tcall_period_timer #(
    .CNT_W (CNT_W)
  ) u_timer (
    .clk          (clk),
    .rst_n        (rst_n),
    .period_we    (period_we),
    .period_wdata (period_wdata),
    .expire       (expire)
  );

  tcall_request_gate u_gate (
    .clk           (clk),
    .rst_n         (rst_n),
    .expire        (expire),
    .cfg_clear     (cfg_clear),
    .insn_boundary (insn_boundary),
    .aug_pending   (aug_pending),
    .alt_pending   (alt_pending),
    .entry_idle    (entry_idle),
    .take          (take)
  );

  tcall_entry_pad #(
    .ADDR_W     (ADDR_W),
    .FLAG_W     (FLAG_W),
    .LAT_CYCLES (LAT_CYCLES)
  ) u_entry (
    .clk            (clk),
    .rst_n          (rst_n),
    .take           (take),
    .cur_pc         (cur_pc),
    .cur_flags      (cur_flags),
    .ret_done       (ret_done),
    .entry_idle     (entry_idle),
    .stall_req      (stall_req),
    .inject_call    (inject_call),
    .handler_active (handler_active),
    .save_pc        (save_pc),
    .save_flags     (save_flags)
  );

endmodule

// File: rtl/tcall_injector_checker.sv
module tcall_injector_checker #(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned FLAG_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              insn_boundary,
  input logic              aug_pending,
  input logic              alt_pending,
  input logic [ADDR_W-1:0] cur_pc,
  input logic [FLAG_W-1:0] cur_flags,
  input logic              ret_done,
  input logic              stall_req,
  input logic              inject_call,
  input logic              handler_active,
  input logic [ADDR_W-1:0] save_pc,
  input logic [FLAG_W-1:0] save_flags
);

  p_inject_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    inject_call |=> !inject_call);

  p_inject_in_pad_r5: assert property (@(posedge clk) disable iff (!rst_n)
    inject_call |-> stall_req);

  p_no_take_aug_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_req && !$past(stall_req)) |-> !$past(aug_pending));

  p_no_take_alt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_req && !$past(stall_req)) |-> !$past(alt_pending));

  p_take_boundary_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_req && !$past(stall_req)) |-> $past(insn_boundary));

  p_ctx_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_req && !$past(stall_req)) |->
      (save_pc == $past(cur_pc)) && (save_flags == $past(cur_flags)));

  p_ctx_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_req && $past(stall_req)) |-> ($stable(save_pc) && $stable(save_flags)));

  p_handler_masks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    handler_active |-> !stall_req);

  p_handler_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (handler_active && !ret_done) |=> handler_active);

  p_handler_follows_inject_r7: assert property (@(posedge clk) disable iff (!rst_n)
    inject_call |=> handler_active);

endmodule

bind tcall_injector tcall_injector_checker #(
  .ADDR_W (ADDR_W),
  .FLAG_W (FLAG_W)
) u_checker (
  .clk            (clk),
  .rst_n          (rst_n),
  .insn_boundary  (insn_boundary),
  .aug_pending    (aug_pending),
  .alt_pending    (alt_pending),
  .cur_pc         (cur_pc),
  .cur_flags      (cur_flags),
  .ret_done       (ret_done),
  .stall_req      (stall_req),
  .inject_call    (inject_call),
  .handler_active (handler_active),
  .save_pc        (save_pc),
  .save_flags     (save_flags)
);

// File: tb/tcall_injector_test.sv
`timescale 1ns/1ps
module tcall_injector_test;

  localparam int CNT_W  = 8;
  localparam int ADDR_W = 12;
  localparam int FLAG_W = 2;
  localparam int LAT    = 4;

  logic              clk;
  logic              rst_n;
  logic              period_we;
  logic [CNT_W-1:0]  period_wdata;
  logic              target_we;
  logic [ADDR_W-1:0] target_wdata;
  logic              insn_boundary;
  logic              aug_pending;
  logic              alt_pending;
  logic [ADDR_W-1:0] cur_pc;
  logic [FLAG_W-1:0] cur_flags;
  logic              ret_done;
  logic              stall_req;
  logic              inject_call;
  logic [ADDR_W-1:0] inject_target;
  logic [ADDR_W-1:0] save_pc;
  logic [FLAG_W-1:0] save_flags;
  logic              handler_active;

  tcall_injector #(
    .CNT_W (CNT_W), .ADDR_W (ADDR_W), .FLAG_W (FLAG_W), .LAT_CYCLES (LAT)
  ) uut (
    .clk (clk), .rst_n (rst_n),
    .period_we (period_we), .period_wdata (period_wdata),
    .target_we (target_we), .target_wdata (target_wdata),
    .insn_boundary (insn_boundary), .aug_pending (aug_pending),
    .alt_pending (alt_pending), .cur_pc (cur_pc), .cur_flags (cur_flags),
    .ret_done (ret_done), .stall_req (stall_req), .inject_call (inject_call),
    .inject_target (inject_target), .save_pc (save_pc),
    .save_flags (save_flags), .handler_active (handler_active)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // Expectation state, derived from the requirements.
  int                cyc = 0;
  int                per_now = 0;
  int                wr_cyc = 0;
  int                take_cyc = 0;
  bit                m_pend = 0;
  bit                m_pad = 0;
  bit                m_hnd = 0;
  logic [ADDR_W-1:0] m_tgt = '0;
  logic [ADDR_W-1:0] m_spc = '0;
  logic [FLAG_W-1:0] m_sflg = '0;
  bit                stall_seen = 0;
  bit                inject_seen = 0;
  logic [ADDR_W-1:0] pc_run = '0;

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit expiry_due(input int c, input bit pwe);
    if (per_now == 0 || pwe || c <= wr_cyc) return 1'b0;
    return ((c - wr_cyc) % per_now) == 0;
  endfunction

  task automatic step(input bit b, input bit a, input bit t, input bit rd,
                      input bit pwe, input logic [CNT_W-1:0] pw,
                      input bit twe, input logic [ADDR_W-1:0] tw);
    bit e_exp, e_take, e_inj;
    logic [ADDR_W-1:0] pc_now;
    logic [FLAG_W-1:0] fl_now;
    pc_now = pc_run;
    fl_now = FLAG_W'($urandom);
    insn_boundary = b; aug_pending = a; alt_pending = t; ret_done = rd;
    period_we = pwe; period_wdata = pw; target_we = twe; target_wdata = tw;
    cur_pc = pc_now; cur_flags = fl_now;
    #1;
    e_exp  = expiry_due(cyc, pwe);
    e_take = m_pend && b && !a && !t && !m_pad && !m_hnd && !pwe && !twe;
    e_inj  = m_pad && (cyc == take_cyc + LAT);
    chk(inject_call == e_inj, "R5 inject cycle", 32'(inject_call), 32'(e_inj));
    chk(stall_req == m_pad, "R5 pad window", 32'(stall_req), 32'(m_pad));
    chk(handler_active == m_hnd, "R7 handler flag", 32'(handler_active), 32'(m_hnd));
    chk(inject_target == m_tgt, "R1 target", 32'(inject_target), 32'(m_tgt));
    chk(save_pc == m_spc, "R6 saved pc", 32'(save_pc), 32'(m_spc));
    chk(save_flags == m_sflg, "R6 saved flags", 32'(save_flags), 32'(m_sflg));
    if (stall_req) stall_seen = 1'b1;
    if (inject_call) inject_seen = 1'b1;
    @(posedge clk);
    if (pwe) begin per_now = int'(pw); wr_cyc = cyc; end
    if (twe) m_tgt = tw;
    if (pwe || twe) m_pend = 1'b0;
    else if (e_exp) m_pend = 1'b1;
    else if (e_take) m_pend = 1'b0;
    if (e_take) begin
      m_pad = 1'b1; take_cyc = cyc; m_spc = pc_now; m_sflg = fl_now;
    end else if (e_inj) begin
      m_pad = 1'b0; m_hnd = 1'b1;
    end else if (m_hnd && rd) begin
      m_hnd = 1'b0;
    end
    if (b && !stall_req) pc_run = pc_run + ADDR_W'(1);
    cyc++;
    @(negedge clk);
  endtask

  task automatic run(input int n, input bit b, input bit a, input bit t, input bit rd);
    for (int i = 0; i < n; i++) step(b, a, t, rd, 1'b0, '0, 1'b0, '0);
  endtask

  task automatic set_period(input int p);
    step(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, CNT_W'(p), 1'b0, '0);
  endtask

  task automatic drain();
    set_period(0);
    run(LAT + 4, 1'b1, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL R5 watchdog expired actual=%0d expected=%0d", cyc, 0);
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5A17));
    rst_n = 1'b0;
    insn_boundary = 0; aug_pending = 0; alt_pending = 0; ret_done = 0;
    period_we = 0; period_wdata = '0; target_we = 0; target_wdata = '0;
    cur_pc = '0; cur_flags = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9: reset state
    chk(inject_call == 1'b0, "R9 inject at reset", 32'(inject_call), 0);
    chk(stall_req == 1'b0, "R9 stall at reset", 32'(stall_req), 0);
    chk(handler_active == 1'b0, "R9 handler at reset", 32'(handler_active), 0);
    chk(save_pc == '0, "R9 saved pc at reset", 32'(save_pc), 0);
    chk(inject_target == '0, "R9 target at reset", 32'(inject_target), 0);
    rst_n = 1'b1;
    stall_seen = 0;
    run(20, 1'b1, 1'b0, 1'b0, 1'b1);
    chk(stall_seen == 1'b0, "R9 timer idle after reset", 32'(stall_seen), 0);

    // R1: basic periodic calls
    step(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, CNT_W'(5), 1'b1, 12'h3A5);
    inject_seen = 0;
    run(40, 1'b1, 1'b0, 1'b0, 1'b1);
    chk(inject_seen == 1'b1, "R1 periodic call taken", 32'(inject_seen), 1);
    chk(inject_target == 12'h3A5, "R1 target port", 32'(inject_target), 32'h3A5);

    // R3: extension prefix holds off the call, request not lost
    drain();
    set_period(3);
    stall_seen = 0;
    run(30, 1'b1, 1'b1, 1'b0, 1'b1);
    chk(stall_seen == 1'b0, "R3 no entry under extension prefix", 32'(stall_seen), 0);
    run(3, 1'b1, 1'b0, 1'b0, 1'b1);
    chk(stall_seen == 1'b1, "R3 entry after prefix clears", 32'(stall_seen), 1);

    // R4: field-rewrite prefix holds off the call
    drain();
    set_period(3);
    stall_seen = 0;
    run(30, 1'b1, 1'b0, 1'b1, 1'b1);
    chk(stall_seen == 1'b0, "R4 no entry under rewrite prefix", 32'(stall_seen), 0);
    run(3, 1'b1, 1'b0, 1'b0, 1'b1);
    chk(stall_seen == 1'b1, "R4 entry after prefix clears", 32'(stall_seen), 1);

    // R10: no boundary, no entry
    drain();
    set_period(2);
    stall_seen = 0;
    run(20, 1'b0, 1'b0, 1'b0, 1'b1);
    chk(stall_seen == 1'b0, "R10 no entry without boundary", 32'(stall_seen), 0);

    // R2: zero period disables
    drain();
    stall_seen = 0;
    run(50, 1'b1, 1'b0, 1'b0, 1'b1);
    chk(stall_seen == 1'b0, "R2 zero period silent", 32'(stall_seen), 0);

    // R7: masked while routine runs, expiry kept pending
    set_period(3);
    run(3 + LAT + 3, 1'b1, 1'b0, 1'b0, 1'b0);
    chk(handler_active == 1'b1, "R7 routine entered", 32'(handler_active), 1);
    stall_seen = 0;
    run(20, 1'b1, 1'b0, 1'b0, 1'b0);
    chk(handler_active == 1'b1, "R7 held until return", 32'(handler_active), 1);
    chk(stall_seen == 1'b0, "R7 no nested entry", 32'(stall_seen), 0);
    run(1, 1'b1, 1'b0, 1'b0, 1'b1);
    run(2, 1'b1, 1'b0, 1'b0, 1'b0);
    chk(stall_seen == 1'b1, "R7 pending taken after return", 32'(stall_seen), 1);

    // R8: config write clears a pending request
    drain();
    set_period(7);
    run(9, 1'b1, 1'b1, 1'b0, 1'b1);
    step(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, '0, 1'b1, 12'h0F0);
    stall_seen = 0;
    run(2, 1'b1, 1'b0, 1'b0, 1'b1);
    chk(stall_seen == 1'b0, "R8 pending cleared by write", 32'(stall_seen), 0);

    // Random mix checked cycle by cycle against the expectation state
    for (int i = 0; i < 20000; i++) begin
      bit pwe, twe;
      pwe = ($urandom_range(0, 199) == 0);
      twe = ($urandom_range(0, 299) == 0);
      step($urandom_range(0, 3) != 0, $urandom_range(0, 4) == 0,
           $urandom_range(0, 5) == 0, $urandom_range(0, 2) == 0,
           pwe, CNT_W'($urandom_range(0, 14)), twe, ADDR_W'($urandom));
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule